// File: doc/BRIEF.md
# Serial Peripheral Controller with Transfer Request Strobes

This block is a single-channel serial peripheral controller. It can act as the clock-driving side (master) or as the clock-following side (slave) of an 8-bit link. Software configures it through a small register window: a control word, a transmit holding register, a receive register and a status word. In master mode the serial clock is made from the system clock by a power-of-two divider chosen by a 3-bit rate code. In slave mode an external serial clock is resynchronised into the system domain and its edges drive the shifter. The rate code has no effect in slave mode.

Two strobes go to an interrupt controller so that a DMA engine can be started. The transmit strobe fires when held transmit data moves into the shifter. The receive strobe fires when a finished frame lands in the receive register. Each strobe has its own enable bit.

Top module: `spi_dma_ctrl`

## Requirements
- R1: After reset the control word (address 0), the receive register (address 2) and the status word (address 3) all read 0. `sclk_out`, `tx_req` and `rx_req` are low.
- R2: In master mode the serial clock period is 2^(rate+1) system clock cycles. Rate code 0 gives /2 and code 7 gives /256. Control word layout: bit0 enable, bit1 master, bits 4:2 rate, bit5 transmit strobe enable, bit6 receive strobe enable.
- R3: A frame is 8 bits, most significant bit first. The clock idles low. `sdo` is stable at each rising serial clock edge and changes only on falling edges. `sdi` is sampled on rising edges. The received byte reads back at address 2.
- R4: In slave mode the shifter is driven by `sclk_in` after a two-flop synchroniser. `sclk_out` stays low and the rate code is ignored.
- R5: While enable is 0 no transfer runs. Data written to address 1 is held: status reads busy=0 (bit0) and pending=1 (bit1). The held data is sent once enable is set.
- R6: `tx_req` pulses when held data is loaded into the shifter, only if the transmit strobe enable is 1.
- R7: `rx_req` pulses when a finished frame is loaded into the receive register, only if the receive strobe enable is 1.
- R8: Writes to the rate and master fields take effect only while enable is 0. Writes made while enable is 1 leave those fields unchanged.
- R9: Busy (status bit0) is 1 from the shifter load until the last bit is shifted. A write to address 1 while busy is held (pending, status bit1) and then sent as the next frame.
- R10: Each strobe is high for exactly one system clock cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 control, 1 transmit, 2 receive, 3 status |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sclk_in | input | 1 | Serial clock from an external master in slave mode |
| sdi | input | 1 | Serial data into the shifter |
| sdo | output | 1 | Serial data out of the shifter |
| tx_req | output | 1 | Transmit transfer request strobe |
| rx_req | output | 1 | Receive transfer request strobe |

## Verification
Several internal faults show up at the ports. A wrong bit counter or shifter state appears within one frame as a misordered byte on `sdo` or in the receive register. A divider fault appears at the second serial clock rising edge, as an edge spacing other than 2^(rate+1) cycles. A lost or duplicated pending flag shows up at the end of the current frame, as a missing second frame or an extra transmit strobe. A configuration field that changes while enabled is visible at once on the next read of the control word.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;

    localparam int WORD_W = 8;
    localparam int RATE_W = 3;
    localparam int ADDR_W = 2;
    localparam int HALF_W = (1 << RATE_W) - 1;

    typedef struct packed {
        logic              rx_req_en;
        logic              tx_req_en;
        logic [RATE_W-1:0] rate;
        logic              master;
        logic              enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 2'd0,
        A_TXD  = 2'd1,
        A_RXD  = 2'd2,
        A_STAT = 2'd3
    } addr_e;

    // last count value of one half serial-clock period: 2^rate - 1
    function automatic logic [HALF_W-1:0] half_limit(input logic [RATE_W-1:0] r);
        return HALF_W'((32'd1 << r) - 32'd1);
    endfunction

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div
    import spi_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              sclk,
    output logic              rise_evt,
    output logic              fall_evt
);
    logic [HALF_W-1:0] cnt;
    logic              sclk_q;
    logic              tick;

    assign tick = run && (cnt == half_limit(rate));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt    <= '0;
            sclk_q <= 1'b0;
        end else if (tick) begin
            cnt    <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

    assign sclk     = sclk_q;
    assign rise_evt = tick && !sclk_q;
    assign fall_evt = tick &&  sclk_q;
endmodule

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= 1'b0;
            else if (i == 0) chain[i] <= async_in;
            else chain[i] <= chain[(i > 0) ? i - 1 : 0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[STAGES-1];
    end

    assign rise =  chain[STAGES-1] && !prev;
    assign fall = !chain[STAGES-1] &&  prev;
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic [WIDTH-1:0] load_word,
    input  logic             rise_evt,
    input  logic             fall_evt,
    input  logic             sdi,
    output logic             sdo,
    output logic             busy,
    output logic             started,
    output logic             done,
    output logic [WIDTH-1:0] rx_word
);
    localparam int CNT_W = $clog2(WIDTH + 1);

    logic [WIDTH-1:0] sh;
    logic             smp;
    logic [CNT_W-1:0] nbits;
    logic             busy_q, start_q, done_q;
    logic [WIDTH-1:0] rx_q;

    always_ff @(posedge clk) begin
        start_q <= 1'b0;
        done_q  <= 1'b0;
        if (rst) begin
            sh     <= '0;
            smp    <= 1'b0;
            nbits  <= '0;
            busy_q <= 1'b0;
            rx_q   <= '0;
        end else if (!en) begin
            busy_q <= 1'b0;
            nbits  <= '0;
        end else if (load) begin
            sh      <= load_word;
            nbits   <= '0;
            busy_q  <= 1'b1;
            start_q <= 1'b1;
        end else if (busy_q) begin
            if (rise_evt) begin
                smp   <= sdi;
                nbits <= nbits + 1'b1;
            end else if (fall_evt && nbits != '0) begin
                sh <= {sh[WIDTH-2:0], smp};
                if (nbits == CNT_W'(WIDTH)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    rx_q   <= {sh[WIDTH-2:0], smp};
                end
            end
        end
    end

    assign sdo     = sh[WIDTH-1];
    assign busy    = busy_q;
    assign started = start_q;
    assign done    = done_q;
    assign rx_word = rx_q;
endmodule

// File: rtl/spi_dma_ctrl.sv
module spi_dma_ctrl
    import spi_dma_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              sclk_out,
    input  logic              sclk_in,
    input  logic              sdi,
    output logic              sdo,
    output logic              tx_req,
    output logic              rx_req
);
    ctrl_t             ctrl;
    ctrl_t             wv;
    logic [WORD_W-1:0] tx_buf;
    logic              tx_pend;
    logic              wr_ctrl, wr_tx;
    logic              busy, started, done, load;
    logic [WORD_W-1:0] rx_word;
    logic              m_rise, m_fall, s_rise, s_fall, rise_evt, fall_evt;
    logic              cfg_en, cfg_master, cfg_txe, cfg_rxe;
    logic [RATE_W-1:0] cfg_rate;

    assign cfg_en     = ctrl.enable;
    assign cfg_master = ctrl.master;
    assign cfg_rate   = ctrl.rate;
    assign cfg_txe    = ctrl.tx_req_en;
    assign cfg_rxe    = ctrl.rx_req_en;

    assign wv      = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    assign wr_ctrl = bus_wr && (addr_e'(bus_addr) == A_CTRL);
    assign wr_tx   = bus_wr && (addr_e'(bus_addr) == A_TXD);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl.enable    <= wv.enable;
            ctrl.tx_req_en <= wv.tx_req_en;
            ctrl.rx_req_en <= wv.rx_req_en;
            if (!ctrl.enable) begin
                ctrl.master <= wv.master;
                ctrl.rate   <= wv.rate;
            end
        end
    end

    assign load = cfg_en && tx_pend && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_buf  <= '0;
            tx_pend <= 1'b0;
        end else if (wr_tx) begin
            tx_buf  <= bus_wdata;
            tx_pend <= 1'b1;
        end else if (load) begin
            tx_pend <= 1'b0;
        end
    end

    spi_clk_div u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (busy && cfg_master && cfg_en),
        .rate     (cfg_rate),
        .sclk     (sclk_out),
        .rise_evt (m_rise),
        .fall_evt (m_fall)
    );

    spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (sclk_in),
        .rise     (s_rise),
        .fall     (s_fall)
    );

    assign rise_evt = cfg_master ? m_rise : s_rise;
    assign fall_evt = cfg_master ? m_fall : s_fall;

    spi_shift_core #(.WIDTH(WORD_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg_en),
        .load      (load),
        .load_word (tx_buf),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .sdi       (sdi),
        .sdo       (sdo),
        .busy      (busy),
        .started   (started),
        .done      (done),
        .rx_word   (rx_word)
    );

    assign tx_req = started && cfg_txe;
    assign rx_req = done && cfg_rxe;

    always_comb begin
        unique case (addr_e'(bus_addr))
            A_CTRL:  bus_rdata = WORD_W'(ctrl);
            A_TXD:   bus_rdata = tx_buf;
            A_RXD:   bus_rdata = rx_word;
            default: bus_rdata = {{(WORD_W-2){1'b0}}, tx_pend, busy};
        endcase
    end
endmodule

// File: rtl/spi_dma_ctrl_chk.sv
module spi_dma_ctrl_chk
    import spi_dma_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic              master,
    input logic [RATE_W-1:0] rate,
    input logic              tx_req_en,
    input logic              rx_req_en,
    input logic              busy,
    input logic              sclk_out,
    input logic              tx_req,
    input logic              rx_req
);
    // R3
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> !sclk_out);
    // R5
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst) !enable |=> !busy);
    // R6
    tx_gate_chk: assert property (@(posedge clk) disable iff (rst) tx_req |-> (tx_req_en && busy));
    // R7
    rx_gate_chk: assert property (@(posedge clk) disable iff (rst) rx_req |-> (rx_req_en && !busy));
    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst) $past(enable) |-> ($stable(rate) && $stable(master)));
    // R10
    tx_pulse_chk: assert property (@(posedge clk) disable iff (rst) tx_req |=> !tx_req);
    // R10
    rx_pulse_chk: assert property (@(posedge clk) disable iff (rst) rx_req |=> !rx_req);
endmodule

bind spi_dma_ctrl spi_dma_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .enable    (cfg_en),
    .master    (cfg_master),
    .rate      (cfg_rate),
    .tx_req_en (cfg_txe),
    .rx_req_en (cfg_rxe),
    .busy      (busy),
    .sclk_out  (sclk_out),
    .tx_req    (tx_req),
    .rx_req    (rx_req)
);

// File: tb/sim_spi_dma_ctrl.sv
`timescale 1ns/1ps
module sim_spi_dma_ctrl;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       sclk_out, sclk_in = 1'b0, sdi = 1'b0, sdo, tx_req, rx_req;

    int errors = 0;
    int checks = 0;
    int tx_cnt = 0;
    int rx_cnt = 0;
    int sclk_hi = 0;
    int mon_n = 0;
    logic [15:0] mon_sr = '0;
    bit done_flag = 0;

    always #(PERIOD/2) clk = ~clk;

    spi_dma_ctrl u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_out(sclk_out),
        .sclk_in(sclk_in), .sdi(sdi), .sdo(sdo), .tx_req(tx_req), .rx_req(rx_req)
    );

    always @(negedge clk) begin
        if (tx_req) tx_cnt++;
        if (rx_req) rx_cnt++;
        if (sclk_out) sclk_hi++;
    end

    always @(posedge sclk_out) begin
        mon_sr = {mon_sr[14:0], sdo};
        mon_n++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(2'd3, s);
            if (s[1:0] == 2'b00) break;
        end
    endtask

    function automatic logic [7:0] cw(input logic rxe, input logic txe,
                                      input logic [2:0] rate, input logic m, input logic en);
        return {1'b0, rxe, txe, rate, m, en};
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        rd(2'd0, d); chk(d == 8'h00, "R1 ctrl", d, 0);
        rd(2'd2, d); chk(d == 8'h00, "R1 rxd", d, 0);
        rd(2'd3, d); chk(d == 8'h00, "R1 status", d, 0);
        chk(!sclk_out && !tx_req && !rx_req, "R1 outputs", {sclk_out, tx_req, rx_req}, 0);
    endtask

    task automatic t_master(input logic [2:0] rate, input logic [7:0] txb,
                            input logic [7:0] resp, input logic dma);
        logic [7:0] got, d;
        realtime tr0, tr1;
        int t0, r0;
        wr(2'd0, cw(dma, dma, rate, 1'b1, 1'b0));
        wr(2'd0, cw(dma, dma, rate, 1'b1, 1'b1));
        t0 = tx_cnt; r0 = rx_cnt;
        sdi = resp[7];
        wr(2'd1, txb);
        tr0 = 0; tr1 = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge sclk_out);
            got[7-i] = sdo;
            if (i == 0) tr0 = $realtime;
            if (i == 1) tr1 = $realtime;
            @(negedge sclk_out);
            if (i < 7) sdi = resp[6-i];
        end
        wait_idle();
        chk(int'((tr1 - tr0) / PERIOD) == (2 << rate), "R2 period",
            int'((tr1 - tr0) / PERIOD), 2 << rate);
        chk(got == txb, "R3 sdo msb-first", got, txb);
        rd(2'd2, d);
        chk(d == resp, "R3 rx byte", d, resp);
        chk(!sclk_out, "R3 idle low", sclk_out, 0);
        chk(tx_cnt - t0 == (dma ? 1 : 0), "R6/R10 tx_req count", tx_cnt - t0, dma ? 1 : 0);
        chk(rx_cnt - r0 == (dma ? 1 : 0), "R7/R10 rx_req count", rx_cnt - r0, dma ? 1 : 0);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_slave();
        logic [7:0] mbyte = 8'hC3;
        logic [7:0] txb = 8'h96;
        logic [7:0] got, d;
        int t0, r0, h0;
        wr(2'd0, cw(1'b1, 1'b0, 3'd7, 1'b0, 1'b1));
        t0 = tx_cnt; r0 = rx_cnt; h0 = sclk_hi;
        wr(2'd1, txb);
        repeat (4) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            sdi = mbyte[7-i];
            repeat (6) @(negedge clk);
            got[7-i] = sdo;
            sclk_in = 1'b1;
            repeat (6) @(negedge clk);
            sclk_in = 1'b0;
        end
        repeat (8) @(negedge clk);
        rd(2'd3, d);
        chk(d == 8'h00, "R4 slave frame finished", d, 0);
        rd(2'd2, d);
        chk(d == mbyte, "R4 slave rx byte", d, mbyte);
        chk(got == txb, "R4 slave sdo", got, txb);
        chk(sclk_hi == h0, "R4 sclk_out low in slave", sclk_hi - h0, 0);
        chk(tx_cnt == t0, "R6 tx_req gated off", tx_cnt - t0, 0);
        chk(rx_cnt - r0 == 1, "R7 rx_req in slave", rx_cnt - r0, 1);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_disabled();
        logic [7:0] d;
        int t0, h0;
        wr(2'd0, cw(1'b0, 1'b1, 3'd0, 1'b1, 1'b0));
        t0 = tx_cnt; h0 = sclk_hi;
        wr(2'd1, 8'h5A);
        repeat (40) @(negedge clk);
        rd(2'd3, d);
        chk(d == 8'h02, "R5 held while off", d, 2);
        chk(sclk_hi == h0 && tx_cnt == t0, "R5 no activity while off",
            (sclk_hi - h0) + (tx_cnt - t0), 0);
        mon_n = 0;
        wr(2'd0, cw(1'b0, 1'b1, 3'd0, 1'b1, 1'b1));
        wait_idle();
        chk(mon_n == 8 && mon_sr[7:0] == 8'h5A, "R5 held data sent", mon_sr[7:0], 8'h5A);
        chk(tx_cnt - t0 == 1, "R6 tx_req on deferred load", tx_cnt - t0, 1);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_cfg_lock();
        logic [7:0] d;
        wr(2'd0, cw(1'b0, 1'b0, 3'd2, 1'b1, 1'b1));
        wr(2'd0, cw(1'b0, 1'b0, 3'd5, 1'b0, 1'b1));
        rd(2'd0, d);
        chk(d == 8'h0B, "R8 locked while enabled", d, 8'h0B);
        wr(2'd0, 8'h00);
        wr(2'd0, cw(1'b0, 1'b0, 3'd5, 1'b0, 1'b0));
        rd(2'd0, d);
        chk(d == 8'h14, "R8 writable while off", d, 8'h14);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_back2back();
        logic [7:0] d;
        int t0;
        wr(2'd0, cw(1'b0, 1'b1, 3'd1, 1'b1, 1'b1));
        t0 = tx_cnt; mon_n = 0;
        wr(2'd1, 8'hA5);
        repeat (2) @(negedge clk);
        rd(2'd3, d);
        chk(d == 8'h01, "R9 busy during frame", d, 1);
        wr(2'd1, 8'h3C);
        rd(2'd3, d);
        chk(d == 8'h03, "R9 write while busy held", d, 3);
        wait_idle();
        chk(mon_n == 16 && mon_sr == 16'hA53C, "R9 second frame follows", mon_sr, 16'hA53C);
        chk(tx_cnt - t0 == 2, "R9/R10 two tx_req", tx_cnt - t0, 2);
        wr(2'd0, 8'h00);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done_flag) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_master(3'd0, 8'hB4, 8'h69, 1'b1);
        t_master(3'd3, 8'h81, 8'h7E, 1'b0);
        t_master(3'd7, 8'h2D, 8'hD2, 1'b1);
        t_slave();
        t_disabled();
        t_cfg_lock();
        t_back2back();
        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule